// File: doc/BRIEF.md
# Vertex Projection to Frame-Buffer Address

This block takes one vertex that has already been transformed into homogeneous clip coordinates, together with its colour. It turns the vertex into a single pixel write. The x, y and z components are each divided by w, which normalises them so that visible points fall in the range -1 to +1. The normalised x and y are then stretched over the screen, which is given at run time as a width and a height. Points that land off the screen are discarded. The remaining pixel position is turned into a byte address inside a frame buffer whose start address is also a run-time input.

One pipelined signed divider does all three divisions. The three components of a vertex enter it on consecutive clocks, so the block accepts at most one vertex every three cycles and signals this on `in_ready`. Every accepted vertex produces exactly one result beat, in the order the vertices were accepted, after a fixed latency. The write strobe on that beat says whether the pixel may be stored. When it is low, the address output is parked on the frame-buffer base, so an address outside the buffer is never presented. The normalised z comes out as a depth value.

Coordinates enter as signed numbers. The normalised results carry `FRAC` fractional bits, so the value 1.0 is represented as 2^FRAC.

Top module: `vertex_proj`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` and `out_wr_en` are 0 and `in_ready` is 1.
- R2: After a vertex is accepted (`in_valid` and `in_ready` both high at a clock edge), `in_ready` is 0 for the next two cycles and 1 in the third.
- R3: Each accepted vertex yields exactly one `out_valid` pulse. The pulse follows the accepting edge by IN_W+FRAC+4 clock edges, and results leave in acceptance order.
- R4: Division truncates toward zero and handles every combination of operand signs. The depth result equals trunc(z * 2^FRAC / w).
- R5: When SAT_DEPTH is 1, a normalised depth outside the signed IN_W-bit range is clamped to the nearest end of that range, either 2^(IN_W-1)-1 or -2^(IN_W-1).
- R6: The pixel column is px = floor((nx + 2^FRAC) * width / 2^(FRAC+1)), where nx = trunc(x * 2^FRAC / w). The pixel row py is computed the same way from y and the height.
- R7: `out_wr_en` is 1 only when 0 <= px < width and 0 <= py < height. On a beat with `out_wr_en` at 0, `out_addr` equals `fb_base`.
- R8: A vertex with w equal to 0 produces a beat with `out_wr_en` at 0.
- R9: On a write beat, `out_addr` = fb_base + 4 * (py * width + px), taken modulo 2^ADDR_W.
- R10: `out_colour` on a result beat is the colour that arrived with the same vertex.
- R11: Vertices offered back to back are accepted every third cycle, and their results appear exactly three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | A vertex is offered |
| in_ready | output | 1 | The block can accept a vertex in this cycle |
| in_x | input | IN_W | Homogeneous x, signed |
| in_y | input | IN_W | Homogeneous y, signed |
| in_z | input | IN_W | Homogeneous z, signed |
| in_w | input | IN_W | Homogeneous w, signed |
| in_colour | input | COL_W | Colour of the vertex |
| scr_width | input | DIM_W | Screen width in pixels |
| scr_height | input | DIM_W | Screen height in pixels |
| fb_base | input | ADDR_W | Byte address at which the frame buffer starts |
| out_valid | output | 1 | A result beat |
| out_wr_en | output | 1 | The pixel is on screen and may be written |
| out_addr | output | ADDR_W | Byte address of the pixel, or fb_base when the pixel is not written |
| out_colour | output | COL_W | Colour of the vertex |
| out_depth | output | IN_W | Normalised z, signed, with FRAC fractional bits |

## Verification
The bench builds the block with IN_W=24, FRAC=8, COL_W=12, DIM_W=16, ADDR_W=32 and SAT_DEPTH=1. This gives a 32-stage divider, short enough to measure the exact result latency on every vertex. With these values the depth clamp is reached by z/w ratios of only about 2^15, so both ends of the clamp can be exercised. Setting the frame-buffer base near the top of the 32-bit space makes the address wrap reachable. Odd widths and points placed exactly on the screen edges test the floor rounding in the viewport mapping and the half-open clip bounds.

// File: rtl/vp_pkg.sv
package vp_pkg;

   // Component tag carried through the shared divider
   typedef enum logic [1:0] {
      COMP_X = 2'd0,
      COMP_Y = 2'd1,
      COMP_Z = 2'd2
   } comp_e;

   // Issue sequencer phase
   typedef enum logic [1:0] {
      ISS_IDLE = 2'd0,
      ISS_Y    = 2'd1,
      ISS_Z    = 2'd2
   } iss_phase_e;

endpackage

// File: rtl/vp_udiv_pipe.sv
// Unsigned restoring divider, one quotient bit per registered stage.
// The quotient is shifted into the dividend register as the dividend drains out.
module vp_udiv_pipe #(
   parameter int NUM_W = 48,
   parameter int DEN_W = 32,
   parameter int SB_W  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [NUM_W-1:0] in_num,
   input  logic [DEN_W-1:0] in_den,
   input  logic [SB_W-1:0]  in_sb,
   output logic             out_valid,
   output logic [NUM_W-1:0] out_quo,
   output logic [SB_W-1:0]  out_sb
);

   if (NUM_W < 2) begin : g_bad_num
      $error("vp_udiv_pipe: NUM_W must be at least 2");
   end
   if (DEN_W < 1) begin : g_bad_den
      $error("vp_udiv_pipe: DEN_W must be at least 1");
   end

   for (genvar s = 0; s < NUM_W; s++) begin : g_stage
      logic             a_v;
      logic [NUM_W-1:0] a_num;
      logic [DEN_W-1:0] a_rem;
      logic [DEN_W-1:0] a_den;
      logic [SB_W-1:0]  a_sb;
      logic [DEN_W:0]   trial;
      logic [DEN_W:0]   diff;
      logic             fits;

      logic             r_v;
      logic [NUM_W-1:0] r_num;
      logic [DEN_W-1:0] r_rem;
      logic [DEN_W-1:0] r_den;
      logic [SB_W-1:0]  r_sb;

      if (s == 0) begin : g_head
         assign a_v   = in_valid;
         assign a_num = in_num;
         assign a_rem = '0;
         assign a_den = in_den;
         assign a_sb  = in_sb;
      end else begin : g_link
         assign a_v   = g_stage[s-1].r_v;
         assign a_num = g_stage[s-1].r_num;
         assign a_rem = g_stage[s-1].r_rem;
         assign a_den = g_stage[s-1].r_den;
         assign a_sb  = g_stage[s-1].r_sb;
      end

      assign trial = {a_rem, a_num[NUM_W-1]};
      assign diff  = trial - {1'b0, a_den};
      // no borrow means the divisor fits into the partial remainder
      assign fits  = ~diff[DEN_W];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_v <= 1'b0;
         else        r_v <= a_v;
      end

      always_ff @(posedge clk) begin
         r_num <= {a_num[NUM_W-2:0], fits};
         r_rem <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
         r_den <= a_den;
         r_sb  <= a_sb;
      end
   end

   assign out_valid = g_stage[NUM_W-1].r_v;
   assign out_quo   = g_stage[NUM_W-1].r_num;
   assign out_sb    = g_stage[NUM_W-1].r_sb;

endmodule

// File: rtl/vp_sdiv.sv
// Signed fractional divider: quo = trunc(num * 2^FRAC / den).
// Magnitudes go through the unsigned core; the sign is restored at the output.
module vp_sdiv #(
   parameter int IN_W = 32,
   parameter int FRAC = 16,
   parameter int SB_W = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic signed [IN_W-1:0] in_num,
   input  logic signed [IN_W-1:0] in_den,
   input  logic [SB_W-1:0]        in_sb,
   output logic                   out_valid,
   output logic signed [IN_W+FRAC:0] out_quo,
   output logic                   out_dz,
   output logic [SB_W-1:0]        out_sb
);

   localparam int NUM_W = IN_W + FRAC;
   localparam int CSB_W = SB_W + 2;

   logic [IN_W-1:0]  num_mag;
   logic [IN_W-1:0]  den_mag;
   logic [CSB_W-1:0] c_sb_in;
   logic             c_valid;
   logic [NUM_W-1:0] c_quo;
   logic [CSB_W-1:0] c_sb;

   always_comb begin
      num_mag = in_num[IN_W-1] ? (~in_num + 1'b1) : in_num;
      den_mag = in_den[IN_W-1] ? (~in_den + 1'b1) : in_den;
   end

   // sideband: user bits, result negative, divisor zero
   assign c_sb_in = {in_sb, in_num[IN_W-1] ^ in_den[IN_W-1], (in_den == '0)};

   vp_udiv_pipe #(
      .NUM_W(NUM_W),
      .DEN_W(IN_W),
      .SB_W (CSB_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_num   ({num_mag, {FRAC{1'b0}}}),
      .in_den   (den_mag),
      .in_sb    (c_sb_in),
      .out_valid(c_valid),
      .out_quo  (c_quo),
      .out_sb   (c_sb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= c_valid;
   end

   always_ff @(posedge clk) begin
      out_quo <= c_sb[1] ? -$signed({1'b0, c_quo}) : $signed({1'b0, c_quo});
      out_dz  <= c_sb[0];
      out_sb  <= c_sb[CSB_W-1:2];
   end

endmodule

// File: rtl/vp_issue.sv
// Accepts a vertex and feeds x, y, z into the shared divider on three consecutive cycles.
module vp_issue
   import vp_pkg::*;
#(
   parameter int IN_W  = 32,
   parameter int COL_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic signed [IN_W-1:0] in_x,
   input  logic signed [IN_W-1:0] in_y,
   input  logic signed [IN_W-1:0] in_z,
   input  logic signed [IN_W-1:0] in_w,
   input  logic [COL_W-1:0]       in_colour,
   output logic                   iss_valid,
   output logic signed [IN_W-1:0] iss_num,
   output logic signed [IN_W-1:0] iss_den,
   output comp_e                  iss_comp,
   output logic [COL_W-1:0]       iss_colour
);

   iss_phase_e             phase;
   logic signed [IN_W-1:0] hold_y;
   logic signed [IN_W-1:0] hold_z;
   logic signed [IN_W-1:0] hold_w;
   logic [COL_W-1:0]       hold_col;
   logic                   take;

   assign in_ready = (phase == ISS_IDLE);
   assign take     = in_ready && in_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= ISS_IDLE;
      end else begin
         case (phase)
            ISS_IDLE: if (in_valid) phase <= ISS_Y;
            ISS_Y:    phase <= ISS_Z;
            default:  phase <= ISS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         hold_y   <= in_y;
         hold_z   <= in_z;
         hold_w   <= in_w;
         hold_col <= in_colour;
      end
   end

   always_comb begin
      iss_valid  = take || (phase != ISS_IDLE);
      iss_den    = hold_w;
      iss_colour = hold_col;
      case (phase)
         ISS_IDLE: begin
            iss_num    = in_x;
            iss_den    = in_w;
            iss_comp   = COMP_X;
            iss_colour = in_colour;
         end
         ISS_Y: begin
            iss_num  = hold_y;
            iss_comp = COMP_Y;
         end
         default: begin
            iss_num  = hold_z;
            iss_comp = COMP_Z;
         end
      endcase
   end

endmodule

// File: rtl/vp_raster.sv
// Gathers the three quotients, maps to the viewport, clips, and forms the byte address.
module vp_raster
   import vp_pkg::*;
#(
   parameter int IN_W      = 32,
   parameter int FRAC      = 16,
   parameter int COL_W     = 16,
   parameter int DIM_W     = 16,
   parameter int ADDR_W    = 32,
   parameter bit SAT_DEPTH = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          q_valid,
   input  logic signed [IN_W+FRAC:0]     q_quo,
   input  logic                          q_dz,
   input  comp_e                         q_comp,
   input  logic [COL_W-1:0]              q_colour,
   input  logic [DIM_W-1:0]              scr_width,
   input  logic [DIM_W-1:0]              scr_height,
   input  logic [ADDR_W-1:0]             fb_base,
   output logic                          out_valid,
   output logic                          out_wr_en,
   output logic [ADDR_W-1:0]             out_addr,
   output logic [COL_W-1:0]              out_colour,
   output logic signed [IN_W-1:0]        out_depth
);

   localparam int QS    = IN_W + FRAC + 1;      // signed quotient width
   localparam int SS    = QS + 1;               // quotient plus one
   localparam int PW    = SS + DIM_W + 1;       // scaled product width
   localparam int IDX_W = 2 * DIM_W;
   localparam int OFF_W = IDX_W + 2;
   localparam logic [SS-1:0] ONE_U = SS'(1) << FRAC;

   // ---------------- collection of x and y ----------------
   logic signed [QS-1:0] nx_r;
   logic signed [QS-1:0] ny_r;
   logic                 dzx_r;
   logic                 dzy_r;

   always_ff @(posedge clk) begin
      if (q_valid && q_comp == COMP_X) begin
         nx_r  <= q_quo;
         dzx_r <= q_dz;
      end
      if (q_valid && q_comp == COMP_Y) begin
         ny_r  <= q_quo;
         dzy_r <= q_dz;
      end
   end

   // ---------------- viewport scaling ----------------
   logic signed [SS-1:0]    x_sum;
   logic signed [SS-1:0]    y_sum;
   logic signed [DIM_W:0]   wid_s;
   logic signed [DIM_W:0]   hgt_s;
   logic signed [PW-1:0]    x_prod;
   logic signed [PW-1:0]    y_prod;
   logic signed [PW-1:0]    x_pix;
   logic signed [PW-1:0]    y_pix;
   logic signed [IN_W-1:0]  depth_c;
   logic                    fire_z;

   assign fire_z = q_valid && (q_comp == COMP_Z);
   assign x_sum  = $signed({nx_r[QS-1], nx_r}) + $signed(ONE_U);
   assign y_sum  = $signed({ny_r[QS-1], ny_r}) + $signed(ONE_U);
   assign wid_s  = $signed({1'b0, scr_width});
   assign hgt_s  = $signed({1'b0, scr_height});
   assign x_prod = PW'(x_sum) * PW'(wid_s);
   assign y_prod = PW'(y_sum) * PW'(hgt_s);
   // arithmetic shift gives floor for negative products
   assign x_pix  = x_prod >>> (FRAC + 1);
   assign y_pix  = y_prod >>> (FRAC + 1);

   // ---------------- depth format variant ----------------
   if (SAT_DEPTH) begin : g_depth_sat
      logic [QS-IN_W:0] hi;
      logic             in_range;
      assign hi       = q_quo[QS-1:IN_W-1];
      assign in_range = (&hi) || !(|hi);
      always_comb begin
         if (in_range)          depth_c = q_quo[IN_W-1:0];
         else if (q_quo[QS-1])  depth_c = {1'b1, {(IN_W-1){1'b0}}};
         else                   depth_c = {1'b0, {(IN_W-1){1'b1}}};
      end
   end else begin : g_depth_wrap
      assign depth_c = q_quo[IN_W-1:0];
   end

   // ---------------- stage 1 ----------------
   logic                   s1_valid;
   logic signed [PW-1:0]   s1_px;
   logic signed [PW-1:0]   s1_py;
   logic                   s1_dz;
   logic [COL_W-1:0]       s1_col;
   logic signed [IN_W-1:0] s1_depth;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= fire_z;
   end

   always_ff @(posedge clk) begin
      if (fire_z) begin
         s1_px    <= x_pix;
         s1_py    <= y_pix;
         s1_dz    <= dzx_r | dzy_r | q_dz;
         s1_col   <= q_colour;
         s1_depth <= depth_c;
      end
   end

   // ---------------- clip and address ----------------
   logic              px_ok;
   logic              py_ok;
   logic              keep;
   logic [IDX_W-1:0]  pix_idx;
   logic [OFF_W-1:0]  byte_off;
   logic [ADDR_W-1:0] off_a;

   assign px_ok = !s1_px[PW-1] && (s1_px[PW-2:0] < (PW-1)'(scr_width));
   assign py_ok = !s1_py[PW-1] && (s1_py[PW-2:0] < (PW-1)'(scr_height));
   assign keep  = s1_valid && !s1_dz && px_ok && py_ok;

   assign pix_idx  = IDX_W'(s1_py[DIM_W-1:0]) * IDX_W'(scr_width) + IDX_W'(s1_px[DIM_W-1:0]);
   assign byte_off = {pix_idx, 2'b00};

   if (ADDR_W >= OFF_W) begin : g_off_ext
      assign off_a = ADDR_W'(byte_off);
   end else begin : g_off_trunc
      assign off_a = byte_off[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_wr_en <= 1'b0;
      end else begin
         out_valid <= s1_valid;
         out_wr_en <= keep;
      end
   end

   always_ff @(posedge clk) begin
      out_addr   <= keep ? (fb_base + off_a) : fb_base;
      out_colour <= s1_col;
      out_depth  <= s1_depth;
   end

endmodule

// File: rtl/vertex_proj.sv
module vertex_proj
   import vp_pkg::*;
#(
   parameter int IN_W      = 32,
   parameter int FRAC      = 16,
   parameter int COL_W     = 16,
   parameter int DIM_W     = 16,
   parameter int ADDR_W    = 32,
   parameter bit SAT_DEPTH = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic signed [IN_W-1:0] in_x,
   input  logic signed [IN_W-1:0] in_y,
   input  logic signed [IN_W-1:0] in_z,
   input  logic signed [IN_W-1:0] in_w,
   input  logic [COL_W-1:0]       in_colour,
   input  logic [DIM_W-1:0]       scr_width,
   input  logic [DIM_W-1:0]       scr_height,
   input  logic [ADDR_W-1:0]      fb_base,
   output logic                   out_valid,
   output logic                   out_wr_en,
   output logic [ADDR_W-1:0]      out_addr,
   output logic [COL_W-1:0]       out_colour,
   output logic signed [IN_W-1:0] out_depth
);

   localparam int QS   = IN_W + FRAC + 1;
   localparam int SB_W = COL_W + 2;

   if (IN_W < 4) begin : g_bad_in
      $error("vertex_proj: IN_W must be at least 4");
   end
   if (FRAC < 1 || FRAC >= IN_W) begin : g_bad_frac
      $error("vertex_proj: FRAC must lie in 1..IN_W-1");
   end
   if (DIM_W < 2) begin : g_bad_dim
      $error("vertex_proj: DIM_W must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("vertex_proj: ADDR_W must be at least 4");
   end
   if (COL_W < 1) begin : g_bad_col
      $error("vertex_proj: COL_W must be at least 1");
   end

   logic                   iss_valid;
   logic signed [IN_W-1:0] iss_num;
   logic signed [IN_W-1:0] iss_den;
   comp_e                  iss_comp;
   logic [COL_W-1:0]       iss_colour;

   logic                   q_valid;
   logic signed [QS-1:0]   q_quo;
   logic                   q_dz;
   logic [SB_W-1:0]        q_sb;

   vp_issue #(
      .IN_W (IN_W),
      .COL_W(COL_W)
   ) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_x      (in_x),
      .in_y      (in_y),
      .in_z      (in_z),
      .in_w      (in_w),
      .in_colour (in_colour),
      .iss_valid (iss_valid),
      .iss_num   (iss_num),
      .iss_den   (iss_den),
      .iss_comp  (iss_comp),
      .iss_colour(iss_colour)
   );

   vp_sdiv #(
      .IN_W(IN_W),
      .FRAC(FRAC),
      .SB_W(SB_W)
   ) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (iss_valid),
      .in_num   (iss_num),
      .in_den   (iss_den),
      .in_sb    ({iss_colour, iss_comp}),
      .out_valid(q_valid),
      .out_quo  (q_quo),
      .out_dz   (q_dz),
      .out_sb   (q_sb)
   );

   vp_raster #(
      .IN_W     (IN_W),
      .FRAC     (FRAC),
      .COL_W    (COL_W),
      .DIM_W    (DIM_W),
      .ADDR_W   (ADDR_W),
      .SAT_DEPTH(SAT_DEPTH)
   ) u_raster (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_valid   (q_valid),
      .q_quo     (q_quo),
      .q_dz      (q_dz),
      .q_comp    (comp_e'(q_sb[1:0])),
      .q_colour  (q_sb[SB_W-1:2]),
      .scr_width (scr_width),
      .scr_height(scr_height),
      .fb_base   (fb_base),
      .out_valid (out_valid),
      .out_wr_en (out_wr_en),
      .out_addr  (out_addr),
      .out_colour(out_colour),
      .out_depth (out_depth)
   );

endmodule

// File: rtl/vertex_proj_chk.sv
module vertex_proj_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] fb_base,
   input logic              out_valid,
   input logic              out_wr_en,
   input logic [ADDR_W-1:0] out_addr
);

   // vertices accepted but not yet delivered
   logic [7:0] inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid);
   end

   // R2: two idle cycles on in_ready after every acceptance
   a_r2_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!in_ready ##1 !in_ready ##1 in_ready));

   // R3: a result never appears without a vertex in flight
   a_r3_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (inflight != 8'd0));

   // R7: strobe only on a result beat
   a_r7_wr_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_en |-> out_valid);

   // R7: a dropped pixel parks the address on the base
   a_r7_park_base: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_wr_en) |-> (out_addr == fb_base));

   // R9: pixel addresses keep the word alignment of the base
   a_r9_word_align: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_en |-> (out_addr[1:0] == fb_base[1:0]));

   // R11: results are at least three cycles apart
   a_r11_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> (!out_valid ##1 !out_valid));

endmodule

bind vertex_proj vertex_proj_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .fb_base  (fb_base),
   .out_valid(out_valid),
   .out_wr_en(out_wr_en),
   .out_addr (out_addr)
);

// File: tb/vertex_proj_tb.sv
`timescale 1ns/1ps
module vertex_proj_tb;

   localparam int IW  = 24;
   localparam int FR  = 8;
   localparam int CW  = 12;
   localparam int DW  = 16;
   localparam int AW  = 32;
   localparam int LAT = IW + FR + 4;
   localparam longint DMAX = (64'sd1 <<< (IW-1)) - 1;
   localparam longint DMIN = -(64'sd1 <<< (IW-1));

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic signed [IW-1:0] in_x = '0;
   logic signed [IW-1:0] in_y = '0;
   logic signed [IW-1:0] in_z = '0;
   logic signed [IW-1:0] in_w = '0;
   logic [CW-1:0]        in_colour = '0;
   logic [DW-1:0]        scr_width = 16'd640;
   logic [DW-1:0]        scr_height = 16'd480;
   logic [AW-1:0]        fb_base = 32'h1000_0000;
   logic                 out_valid;
   logic                 out_wr_en;
   logic [AW-1:0]        out_addr;
   logic [CW-1:0]        out_colour;
   logic signed [IW-1:0] out_depth;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;

   typedef struct {
      bit          wr;
      logic [31:0] addr;
      longint      depth;
   } exp_t;

   vertex_proj #(
      .IN_W(IW), .FRAC(FR), .COL_W(CW), .DIM_W(DW), .ADDR_W(AW), .SAT_DEPTH(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_w(in_w), .in_colour(in_colour),
      .scr_width(scr_width), .scr_height(scr_height), .fb_base(fb_base),
      .out_valid(out_valid), .out_wr_en(out_wr_en), .out_addr(out_addr),
      .out_colour(out_colour), .out_depth(out_depth)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(string req, string what, longint act, longint exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic exp_t model(int x, int y, int z, int w, int wid, int hgt, logic [31:0] base);
      exp_t   e;
      longint nx, ny, nz, px, py, idx;
      e.depth = 0;
      if (w == 0) begin
         e.wr   = 1'b0;
         e.addr = base;
         return e;
      end
      nx = (longint'(x) * 256) / longint'(w);
      ny = (longint'(y) * 256) / longint'(w);
      nz = (longint'(z) * 256) / longint'(w);
      px = ((nx + 256) * longint'(wid)) >>> 9;
      py = ((ny + 256) * longint'(hgt)) >>> 9;
      e.depth = (nz > DMAX) ? DMAX : (nz < DMIN) ? DMIN : nz;
      e.wr = (px >= 0) && (px < wid) && (py >= 0) && (py < hgt);
      idx = py * wid + px;
      e.addr = e.wr ? (base + 32'(idx * 4)) : base;
      return e;
   endfunction

   task automatic put(int x, int y, int z, int w, int col);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid  = 1'b1;
      in_x      = x[IW-1:0];
      in_y      = y[IW-1:0];
      in_z      = z[IW-1:0];
      in_w      = w[IW-1:0];
      in_colour = col[CW-1:0];
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic one(string req, int x, int y, int z, int w, int col);
      exp_t e;
      bit   seen = 1'b0;
      int   lat = 0;
      e = model(x, y, z, w, int'(scr_width), int'(scr_height), fb_base);
      put(x, y, z, w, col);
      for (int k = 1; k <= LAT + 20; k++) begin
         @(posedge clk);
         #1;
         if (out_valid) begin
            seen = 1'b1;
            lat  = k;
            break;
         end
      end
      check({req, " R3"}, "result seen", longint'(seen), 1);
      if (seen) begin
         check("R3", "latency", lat, LAT);
         check({req, " R7"}, "write strobe", longint'(out_wr_en), longint'(e.wr));
         check({req, " R9"}, "address", longint'({32'b0, out_addr}), longint'({32'b0, e.addr}));
         check("R10", "colour", longint'(out_colour), longint'(col[CW-1:0]));
         if (w != 0) check({req, " R4"}, "depth", longint'(out_depth), e.depth);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "out_valid in reset", longint'(out_valid), 0);
      check("R1", "out_wr_en in reset", longint'(out_wr_en), 0);
      check("R1", "in_ready in reset", longint'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "out_valid after reset", longint'(out_valid), 0);
      check("R1", "in_ready after reset", longint'(in_ready), 1);
   endtask

   task automatic t_ready_gap();
      put(0, 0, 0, 1, 1);
      check("R2", "ready one cycle after", longint'(in_ready), 0);
      @(posedge clk); #1;
      check("R2", "ready two cycles after", longint'(in_ready), 0);
      @(posedge clk); #1;
      check("R2", "ready three cycles after", longint'(in_ready), 1);
      repeat (LAT + 4) @(posedge clk);
   endtask

   task automatic t_centre();
      scr_width = 16'd640; scr_height = 16'd480; fb_base = 32'h1000_0000;
      one("R6", 0, 0, 0, 1, 12'hABC);
      one("R6", 1, -1, 2, 4, 12'h123);
   endtask

   task automatic t_signs();
      one("R4", -3, 5, -7, 10, 12'h011);
      one("R4", 3, -5, 7, -4, 12'h022);
      one("R4", -9, -9, 9, -9, 12'h033);
   endtask

   task automatic t_clip();
      one("R7", 10, 0, 0, 10, 12'h101);
      one("R7", -10, 0, 0, 10, 12'h102);
      one("R7", 0, 10, 0, 10, 12'h103);
      one("R7", 99, 0, 0, 100, 12'h104);
      one("R7", 0, -25, 0, 10, 12'h105);
   endtask

   task automatic t_wzero();
      one("R8", 5, 5, 5, 0, 12'h200);
   endtask

   task automatic t_depth();
      one("R5", 0, 0, 1 << 20, 1, 12'h301);
      one("R5", 0, 0, -(1 << 20), 1, 12'h302);
   endtask

   task automatic t_odd();
      scr_width = 16'd641; scr_height = 16'd3;
      one("R6", 1, 1, 0, 3, 12'h401);
      one("R6", -1, -1, 0, 3, 12'h402);
      scr_width = 16'd640; scr_height = 16'd480;
   endtask

   task automatic t_wrap();
      fb_base = 32'hFFFF_FF00;
      one("R9", 0, 0, 0, 1, 12'h501);
      fb_base = 32'h1000_0000;
   endtask

   task automatic t_stream();
      int   xs [4] = '{0, -5, 7, 3};
      int   ys [4] = '{0, 4, -2, 3};
      int   ws [4] = '{1, 10, 9, 4};
      exp_t es [4];
      for (int i = 0; i < 4; i++)
         es[i] = model(xs[i], ys[i], i, ws[i], int'(scr_width), int'(scr_height), fb_base);
      fork
         begin
            for (int i = 0; i < 4; i++) put(xs[i], ys[i], i, ws[i], 12'h600 + i);
         end
         begin
            int got  = 0;
            int last = 0;
            for (int k = 0; k < LAT + 40 && got < 4; k++) begin
               @(posedge clk);
               #1;
               if (out_valid) begin
                  if (got > 0) check("R11", "result spacing", cyc - last, 3);
                  last = cyc;
                  check("R11 R10", "stream colour", longint'(out_colour), longint'(12'h600 + got));
                  check("R11 R9", "stream address", longint'({32'b0, out_addr}),
                        longint'({32'b0, es[got].addr}));
                  got++;
               end
            end
            check("R11 R3", "stream result count", got, 4);
         end
      join
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_ready_gap();
      t_centre();
      t_signs();
      t_clip();
      t_wzero();
      t_depth();
      t_odd();
      t_wrap();
      t_stream();
      repeat (5) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule